// File: doc/BRIEF.md
# Debounced Reset Pulse Generator

This block merges three reset causes into one stretched system reset: a digital supply-good flag from an external comparator, an active-low push-button, and a timeout request from a watchdog. The push-button is first brought into the clock domain. It is then debounced against a millisecond tick enable, so a press counts only after the button has stayed low for a minimum number of ticks.

Whenever any cause is present, a stretch counter is loaded with its full count. It counts down on tick enables only once every cause has gone away, and reset is released when it reaches zero. A power-on reset forces reset active and loads the full count. The block drives an active-high reset, its active-low complement, and a reset-active indication that goes back to the watchdog.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `por_n` is low, `rst_out`=1. After `por_n` rises, with no cause present, reset stays active through 249 tick enables and drops in the cycle after the 250th tick.
- R2: When `supply_ok` is sampled low, reset is active from the next cycle and stays active while `supply_ok` stays low, however many ticks occur.
- R3: Ticks that arrive while a cause is present do not shorten the hold. Reset is released only after 250 ticks have been counted with every cause absent.
- R4: A push-button press asserts reset only after the synchronised `btn_n` has been sampled low on 20 tick enables in a row. Reset then becomes active in the following cycle.
- R5: Any high sample of the synchronised push-button clears the debounce count. A press shorter than 20 ticks never asserts reset.
- R6: After a recognised press, reset stays active while the button is held and for 250 ticks after the release.
- R7: A single-cycle `wdt_expire` pulse gives a reset that is active for 250 ticks.
- R8: A `wdt_expire` pulse while reset is already active reloads the full 250-tick hold.
- R9: `rst_out_n` is always the inverse of `rst_out`, and `rst_active` always equals `rst_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick_ms | input | 1 | One-cycle millisecond tick enable |
| supply_ok | input | 1 | Supply-within-tolerance flag, high when good |
| btn_n | input | 1 | Asynchronous push-button, low when pressed |
| wdt_expire | input | 1 | Watchdog timeout request, one cycle |
| rst_out | output | 1 | System reset, active high |
| rst_out_n | output | 1 | System reset, active low |
| rst_active | output | 1 | Reset-active indication to the watchdog |

## Verification
The bench counts ticks up to the exact release edge after power-on, after a supply drop and after a button release. A stretch counter that is off by one, or that decrements while a cause is still present, releases one tick early or holds several ticks too long. A press broken by a single high sample must restart the debounce: a counter that only pauses would reach 20 early and reset the system on a bouncing contact. A watchdog pulse in the middle of a hold must restart the full count. A design that ignores it would release 150 ticks later instead of 250.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
   typedef struct packed {
      logic supply_low;
      logic button;
      logic watchdog;
   } rpg_cause_t;

   function automatic logic rpg_any(input rpg_cause_t c);
      return c.supply_low | c.button | c.watchdog;
   endfunction
endpackage

// File: rtl/rpg_sync.sv
module rpg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("rpg_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {STAGES{RST_VAL}};
            else        sh <= {sh[STAGES-2+1-1:0], d} >> 0;
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rpg_debounce.sv
module rpg_debounce #(
   parameter int TICKS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic level_n,
   output logic pressed
);
   localparam int W = $clog2(TICKS + 1);
   localparam logic [W-1:0] FULL = W'(TICKS);

   generate
      if (TICKS < 1) begin : g_bad
         $error("rpg_debounce: TICKS must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (level_n)            cnt <= '0;
      else if (tick && cnt != FULL) cnt <= cnt + 1'b1;
   end

   assign pressed = (cnt == FULL);

   AST_DEB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      level_n |=> !pressed); // R5
   AST_DEB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL); // R4
   AST_DEB_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pressed) |-> $past(tick) && !$past(level_n)); // R4
endmodule

// File: rtl/rpg_stretch.sv
module rpg_stretch #(
   parameter int TICKS = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic cause,
   output logic rst
);
   localparam int W = $clog2(TICKS + 1);
   localparam logic [W-1:0] FULL = W'(TICKS);

   generate
      if (TICKS < 1) begin : g_bad
         $error("rpg_stretch: TICKS must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= FULL;
      else if (cause)             cnt <= FULL;
      else if (tick && cnt != '0) cnt <= cnt - 1'b1;
   end

   assign rst = (cnt != '0);

   AST_CAUSE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      cause |=> (cnt == FULL) && rst); // R8
   AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst) |-> $past(tick) && !$past(cause)); // R3
   AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!cause && !tick) |=> $stable(cnt)); // R3
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
   parameter int SYNC_STAGES   = 2,
   parameter int DEBOUNCE_TICK = 20,
   parameter int STRETCH_TICK  = 250
) (
   input  logic clk,
   input  logic por_n,
   input  logic tick_ms,
   input  logic supply_ok,
   input  logic btn_n,
   input  logic wdt_expire,
   output logic rst_out,
   output logic rst_out_n,
   output logic rst_active
);
   import rpg_pkg::*;

   logic       btn_s;
   logic       pressed;
   logic       rst;
   rpg_cause_t cause;

   rpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(por_n), .d(btn_n), .q(btn_s));

   rpg_debounce #(.TICKS(DEBOUNCE_TICK)) u_deb (
      .clk(clk), .rst_n(por_n), .tick(tick_ms), .level_n(btn_s), .pressed(pressed));

   always_comb begin
      cause.supply_low = ~supply_ok;
      cause.button     = pressed;
      cause.watchdog   = wdt_expire;
   end

   rpg_stretch #(.TICKS(STRETCH_TICK)) u_str (
      .clk(clk), .rst_n(por_n), .tick(tick_ms), .cause(rpg_any(cause)), .rst(rst));

   assign rst_out    = rst;
   assign rst_out_n  = ~rst;
   assign rst_active = rst;

   AST_SUPPLY_LOW_RESETS: assert property (@(posedge clk) disable iff (!por_n)
      !supply_ok |=> rst_out && !rst_out_n); // R2
   AST_WDT_RESETS: assert property (@(posedge clk) disable iff (!por_n)
      wdt_expire |=> rst_out); // R7
   AST_PRESS_RESETS: assert property (@(posedge clk) disable iff (!por_n)
      pressed |=> rst_active); // R6
endmodule

// File: tb/rst_pulse_gen_test.sv
module rst_pulse_gen_test;
   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic tick_ms = 1'b0;
   logic supply_ok = 1'b1;
   logic btn_n = 1'b1;
   logic wdt_expire = 1'b0;
   logic rst_out, rst_out_n, rst_active;
   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   rst_pulse_gen uut (
      .clk(clk), .por_n(por_n), .tick_ms(tick_ms), .supply_ok(supply_ok),
      .btn_n(btn_n), .wdt_expire(wdt_expire),
      .rst_out(rst_out), .rst_out_n(rst_out_n), .rst_active(rst_active));

   // row: [11] supply_ok, [10] expected reset, [9:0] ticks issued
   localparam logic [11:0] VEC [6] = '{
      {1'b0, 1'b1, 10'd5},
      {1'b1, 1'b1, 10'd100},
      {1'b0, 1'b1, 10'd3},
      {1'b1, 1'b1, 10'd249},
      {1'b1, 1'b0, 10'd1},
      {1'b1, 1'b0, 10'd10}
   };

   task automatic check_rst(input logic exp, input string req);
      checks++;
      if (rst_out !== exp || rst_out_n !== ~exp || rst_active !== exp) begin
         failures++;
         $display("FAIL %s: rst_out=%b rst_out_n=%b rst_active=%b expected rst=%b",
                  req, rst_out, rst_out_n, rst_active, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_ms = 1'b1;
         @(negedge clk) tick_ms = 1'b0;
      end
   endtask

   task automatic wdt_pulse();
      @(negedge clk) wdt_expire = 1'b1;
      @(negedge clk) wdt_expire = 1'b0;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1 reset state and power-on hold
      idle(3);
      check_rst(1'b1, "R1 during por");
      ticks(3);
      check_rst(1'b1, "R1 ticks in por");
      @(negedge clk) por_n = 1'b1;
      idle(2);
      ticks(249);
      check_rst(1'b1, "R1 after 249");
      ticks(1);
      check_rst(1'b0, "R1 after 250 R9");

      // R2 R3 table of supply patterns
      foreach (VEC[k]) begin
         @(negedge clk) supply_ok = VEC[k][11];
         idle(1);
         ticks(int'(VEC[k][9:0]));
         check_rst(VEC[k][10], "R2 R3 table row");
      end

      // R4 minimum press length
      @(negedge clk) btn_n = 1'b0;
      idle(3);
      ticks(19);
      check_rst(1'b0, "R4 19 ticks");
      ticks(1);
      idle(1);
      check_rst(1'b1, "R4 20 ticks");
      // R6 hold while pressed, then 250 after release
      ticks(300);
      check_rst(1'b1, "R6 held");
      @(negedge clk) btn_n = 1'b1;
      idle(4);
      ticks(249);
      check_rst(1'b1, "R6 249 after release");
      ticks(1);
      check_rst(1'b0, "R6 250 after release");

      // R5 a bounce restarts the debounce
      @(negedge clk) btn_n = 1'b0;
      idle(3);
      ticks(10);
      @(negedge clk) btn_n = 1'b1;
      idle(3);
      @(negedge clk) btn_n = 1'b0;
      idle(3);
      ticks(19);
      check_rst(1'b0, "R5 bounce restarts");
      ticks(1);
      idle(1);
      check_rst(1'b1, "R5 full count after bounce");
      @(negedge clk) btn_n = 1'b1;
      idle(4);
      ticks(250);
      check_rst(1'b0, "R5 released");
      // R5 short press ignored
      @(negedge clk) btn_n = 1'b0;
      idle(3);
      ticks(19);
      @(negedge clk) btn_n = 1'b1;
      idle(5);
      ticks(2);
      check_rst(1'b0, "R5 short press");

      // R7 single watchdog pulse
      wdt_pulse();
      check_rst(1'b1, "R7 asserted");
      ticks(249);
      check_rst(1'b1, "R7 249");
      ticks(1);
      check_rst(1'b0, "R7 250");

      // R8 reload while active
      wdt_pulse();
      ticks(100);
      wdt_pulse();
      ticks(249);
      check_rst(1'b1, "R8 reloaded 249");
      ticks(1);
      check_rst(1'b0, "R8 reloaded 250");

      // R1 power-on in mid operation
      @(negedge clk) por_n = 1'b0;
      idle(1);
      check_rst(1'b1, "R1 por again R9");
      @(negedge clk) por_n = 1'b1;
      ticks(250);
      check_rst(1'b0, "R1 release again");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule